// File: doc/BRIEF.md
# Two-Way Address Translation Cache with Software Refill

This block turns a 40-bit virtual address into a 36-bit physical address using 16 KiB pages. Translations live in a 512-entry cache organised as 256 sets of two ways. Each lookup compares both ways of the selected set at once. When no valid way holds the page, the block reports a miss and does not walk any page table. System software then picks a translation and installs it through a separate write port.

Every entry has a valid bit, a dirty bit, a reference bit, a two-bit rights field, a tag and a physical page number. A write that hits marks the page dirty, so that it can be written back when it is evicted. Any permitted hit sets the reference bit. Software can clear all reference bits at once and later read which pages were touched, which gives an approximate LRU choice of pages. A per-set pointer names the way that software should replace next. A flush command drops every translation in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: The set index is `reqVaddr[21:14]` and the tag is `reqVaddr[39:22]`. On a hit, `rspPaddr` is the entry's 22-bit page number in bits 35:14, followed by `reqVaddr[13:0]` unchanged.
- R2: A request accepted on one rising edge produces `rspValid` high in the next cycle, with exactly one of `rspHit`, `rspMiss` and `rspProt` high. `rspValid` is low in any cycle that follows an edge with no request.
- R3: Both ways of the indexed set are compared. A hit can come from either way. When no valid way has a matching tag, `rspMiss` is reported, including when the same tag is present in a different set. `rspPaddr` is zero on every outcome other than a hit.
- R4: The rights field is encoded as 00 no access, 01 read only, 10 read/write, and 11 read/write for kernel only (`reqKernel` high). A matching entry whose rights forbid the access raises `rspProt` in place of a hit.
- R5: A write hit sets the entry's dirty bit. A read hit, a protection fault and a miss leave the dirty bit unchanged.
- R6: A permitted hit sets the entry's reference bit. A fault does not set it. `swClrRef` clears the reference bit of every entry, and installing an entry clears that entry's reference bit.
- R7: The per-set replacement pointer `swRdLru` points to the way other than the one most recently hit or installed in that set. A fault or a miss leaves the pointer unchanged.
- R8: `swWrEn` writes the valid, dirty, rights, tag and page-number fields of the chosen set and way. The read port returns these fields, together with the reference bit, combinationally.
- R9: `swFlush` clears the valid bit of every entry in one cycle, and all later lookups miss until software installs new entries. A flush does not change the other fields.
- R10: After reset all valid, dirty and reference bits and all replacement pointers are zero, and no response is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request strobe |
| reqVaddr | input | 40 | Virtual address to translate |
| reqWrite | input | 1 | Request is a store |
| reqKernel | input | 1 | Request comes from kernel mode |
| rspValid | output | 1 | Response present this cycle |
| rspHit | output | 1 | Translation succeeded |
| rspMiss | output | 1 | No matching entry; software refill needed |
| rspProt | output | 1 | Matching entry forbids the access |
| rspPaddr | output | 36 | Physical address on a hit, zero otherwise |
| swWrEn | input | 1 | Install strobe |
| swWrSet | input | 8 | Set to install into |
| swWrWay | input | 1 | Way to install into |
| swWrValid | input | 1 | Valid bit to write |
| swWrDirty | input | 1 | Dirty bit to write |
| swWrRights | input | 2 | Rights field to write |
| swWrTag | input | 18 | Tag to write |
| swWrPpn | input | 22 | Physical page number to write |
| swClrRef | input | 1 | Clear every reference bit |
| swFlush | input | 1 | Clear every valid bit |
| swRdSet | input | 8 | Set to inspect |
| swRdWay | input | 1 | Way to inspect |
| swRdValid | output | 1 | Inspected valid bit |
| swRdDirty | output | 1 | Inspected dirty bit |
| swRdRef | output | 1 | Inspected reference bit |
| swRdRights | output | 2 | Inspected rights field |
| swRdTag | output | 18 | Inspected tag |
| swRdPpn | output | 22 | Inspected physical page number |
| swRdLru | output | 1 | Suggested victim way of the inspected set |

## Verification
A valid or tag bit that is wrong internally appears as a wrong hit, miss or fault one cycle after the next lookup to that set. A wrong dirty bit, reference bit or replacement pointer can be seen on the read port as soon as the edge that updates it has passed, because that port reads the state combinationally. The bench therefore reads the read port right after each write hit, fault, reference clear and install, and looks up again after a flush. It does not wait for some later eviction to expose the error.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    RIGHT_NONE = 2'b00,
    RIGHT_RO   = 2'b01,
    RIGHT_RW   = 2'b10,
    RIGHT_KRW  = 2'b11
  } rights_e;

  // Strobes from control to datapath for one lookup
  typedef struct packed {
    logic touch;      // permitted hit: update ref and LRU
    logic way;        // way that hit
    logic markDirty;  // permitted hit was a store
  } xlat_strobe_t;

endpackage

// File: rtl/xlat_path.sv
module xlat_path
  import xlat_pkg::*;
#(
  parameter int VA_W  = 40,
  parameter int PA_W  = 36,
  parameter int OFF_W = 14,
  parameter int SET_W = 8,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int TAG_W = VPN_W - SET_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int SETS  = 1 << SET_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SET_W-1:0] lookSet,
  input  logic [TAG_W-1:0] lookTag,
  input  xlat_strobe_t     strobe,
  output logic [WAYS-1:0]  matchVec,
  output logic [1:0]       matchRights,
  output logic [PPN_W-1:0] matchPpn,
  input  logic             swWrEn,
  input  logic [SET_W-1:0] swWrSet,
  input  logic             swWrWay,
  input  logic             swWrValid,
  input  logic             swWrDirty,
  input  logic [1:0]       swWrRights,
  input  logic [TAG_W-1:0] swWrTag,
  input  logic [PPN_W-1:0] swWrPpn,
  input  logic             swClrRef,
  input  logic             swFlush,
  input  logic [SET_W-1:0] swRdSet,
  input  logic             swRdWay,
  output logic             swRdValid,
  output logic             swRdDirty,
  output logic             swRdRef,
  output logic [1:0]       swRdRights,
  output logic [TAG_W-1:0] swRdTag,
  output logic [PPN_W-1:0] swRdPpn,
  output logic             swRdLru
);

  logic [SETS-1:0][WAYS-1:0] validQ, dirtyQ, refQ;
  logic [SETS-1:0]           lruQ;
  logic [TAG_W-1:0]          tagQ    [SETS][WAYS];
  logic [PPN_W-1:0]          ppnQ    [SETS][WAYS];
  logic [1:0]                rightsQ [SETS][WAYS];

  // Parallel compare of every way in the indexed set
  for (genvar w = 0; w < WAYS; w++) begin : gCmp
    assign matchVec[w] = validQ[lookSet][w] && (tagQ[lookSet][w] == lookTag);
  end

  assign matchRights = matchVec[1] ? rightsQ[lookSet][1] : rightsQ[lookSet][0];
  assign matchPpn    = matchVec[1] ? ppnQ[lookSet][1]    : ppnQ[lookSet][0];

  for (genvar s = 0; s < SETS; s++) begin : gSet
    logic setWr, setTouch;
    assign setWr    = swWrEn && (swWrSet == SET_W'(s));
    assign setTouch = strobe.touch && (lookSet == SET_W'(s));

    always_ff @(posedge clk) begin
      if (!rstN)         lruQ[s] <= 1'b0;
      else if (setWr)    lruQ[s] <= ~swWrWay;
      else if (setTouch) lruQ[s] <= ~strobe.way;
    end

    for (genvar w = 0; w < WAYS; w++) begin : gWay
      logic wrHit, lkHit;
      assign wrHit = setWr && (swWrWay == 1'(w));
      assign lkHit = setTouch && (strobe.way == 1'(w));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          validQ[s][w] <= 1'b0;
          dirtyQ[s][w] <= 1'b0;
          refQ[s][w]   <= 1'b0;
        end else begin
          if (swFlush)    validQ[s][w] <= 1'b0;
          else if (wrHit) validQ[s][w] <= swWrValid;

          if (wrHit)                         dirtyQ[s][w] <= swWrDirty;
          else if (lkHit && strobe.markDirty) dirtyQ[s][w] <= 1'b1;

          if (wrHit)         refQ[s][w] <= 1'b0;
          else if (lkHit)    refQ[s][w] <= 1'b1;
          else if (swClrRef) refQ[s][w] <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (wrHit) begin
          tagQ[s][w]    <= swWrTag;
          ppnQ[s][w]    <= swWrPpn;
          rightsQ[s][w] <= swWrRights;
        end
      end
    end
  end

  assign swRdValid  = validQ[swRdSet][swRdWay];
  assign swRdDirty  = dirtyQ[swRdSet][swRdWay];
  assign swRdRef    = refQ[swRdSet][swRdWay];
  assign swRdRights = rightsQ[swRdSet][swRdWay];
  assign swRdTag    = tagQ[swRdSet][swRdWay];
  assign swRdPpn    = ppnQ[swRdSet][swRdWay];
  assign swRdLru    = lruQ[swRdSet];

  // R3: software keeps tags unique within a set
  a_r3_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $countones(matchVec) <= 1);

  // R9: one-cycle flush
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    swFlush |=> (validQ == '0));

  // R7: install moves the pointer away from the installed way
  a_r7_lru_install: assert property (@(posedge clk) disable iff (!rstN)
    swWrEn |=> (lruQ[$past(swWrSet)] == ~$past(swWrWay)));

  // R6: permitted hit leaves the reference bit set
  a_r6_ref_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.touch && !(swWrEn && swWrSet == lookSet))
      |=> refQ[$past(lookSet)][$past(strobe.way)]);

  // R5: store hit leaves the dirty bit set
  a_r5_dirty_on_store: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.touch && strobe.markDirty && !(swWrEn && swWrSet == lookSet))
      |=> dirtyQ[$past(lookSet)][$past(strobe.way)]);

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int OFF_W = 14,
  parameter int PPN_W = 22,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqKernel,
  input  logic [OFF_W-1:0] reqOff,
  input  logic [WAYS-1:0]  matchVec,
  input  logic [1:0]       matchRights,
  input  logic [PPN_W-1:0] matchPpn,
  output xlat_strobe_t     strobe,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspMiss,
  output logic             rspProt,
  output logic [PA_W-1:0]  rspPaddr
);

  logic anyMatch, allowed;

  assign anyMatch = |matchVec;

  always_comb begin
    unique case (rights_e'(matchRights))
      RIGHT_NONE: allowed = 1'b0;
      RIGHT_RO:   allowed = !reqWrite;
      RIGHT_RW:   allowed = 1'b1;
      RIGHT_KRW:  allowed = reqKernel;
      default:    allowed = 1'b0;
    endcase
  end

  assign strobe.touch     = reqValid && anyMatch && allowed;
  assign strobe.way       = matchVec[1];
  assign strobe.markDirty = reqWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspProt  <= 1'b0;
      rspPaddr <= '0;
    end else begin
      rspValid <= reqValid;
      rspHit   <= strobe.touch;
      rspMiss  <= reqValid && !anyMatch;
      rspProt  <= reqValid && anyMatch && !allowed;
      rspPaddr <= strobe.touch ? {matchPpn, reqOff} : '0;
    end
  end

  // R2: response follows a request by exactly one cycle
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r2_no_stray_resp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R2: one outcome per response, none without one
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($countones({rspHit, rspMiss, rspProt}) == 1));
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspHit || rspMiss || rspProt));

  // R3: address output only carries a translation on a hit
  a_r3_paddr_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> (rspPaddr == '0));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W  = 40,
  parameter int PA_W  = 36,
  parameter int OFF_W = 14,
  parameter int SET_W = 8,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int TAG_W = VPN_W - SET_W,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  input  logic             reqKernel,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspMiss,
  output logic             rspProt,
  output logic [PA_W-1:0]  rspPaddr,
  input  logic             swWrEn,
  input  logic [SET_W-1:0] swWrSet,
  input  logic             swWrWay,
  input  logic             swWrValid,
  input  logic             swWrDirty,
  input  logic [1:0]       swWrRights,
  input  logic [TAG_W-1:0] swWrTag,
  input  logic [PPN_W-1:0] swWrPpn,
  input  logic             swClrRef,
  input  logic             swFlush,
  input  logic [SET_W-1:0] swRdSet,
  input  logic             swRdWay,
  output logic             swRdValid,
  output logic             swRdDirty,
  output logic             swRdRef,
  output logic [1:0]       swRdRights,
  output logic [TAG_W-1:0] swRdTag,
  output logic [PPN_W-1:0] swRdPpn,
  output logic             swRdLru
);

  logic [SET_W-1:0] lookSet;
  logic [TAG_W-1:0] lookTag;
  logic [OFF_W-1:0] lookOff;
  logic [WAYS-1:0]  matchVec;
  logic [1:0]       matchRights;
  logic [PPN_W-1:0] matchPpn;
  xlat_strobe_t     strobe;

  assign lookOff = reqVaddr[OFF_W-1:0];
  assign lookSet = reqVaddr[OFF_W +: SET_W];
  assign lookTag = reqVaddr[VA_W-1 -: TAG_W];

  xlat_ctrl #(.OFF_W(OFF_W), .PPN_W(PPN_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqKernel(reqKernel),
    .reqOff(lookOff),
    .matchVec(matchVec), .matchRights(matchRights), .matchPpn(matchPpn),
    .strobe(strobe),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss),
    .rspProt(rspProt), .rspPaddr(rspPaddr)
  );

  xlat_path #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .SET_W(SET_W)) uPath (
    .clk(clk), .rstN(rstN),
    .lookSet(lookSet), .lookTag(lookTag), .strobe(strobe),
    .matchVec(matchVec), .matchRights(matchRights), .matchPpn(matchPpn),
    .swWrEn(swWrEn), .swWrSet(swWrSet), .swWrWay(swWrWay),
    .swWrValid(swWrValid), .swWrDirty(swWrDirty), .swWrRights(swWrRights),
    .swWrTag(swWrTag), .swWrPpn(swWrPpn),
    .swClrRef(swClrRef), .swFlush(swFlush),
    .swRdSet(swRdSet), .swRdWay(swRdWay),
    .swRdValid(swRdValid), .swRdDirty(swRdDirty), .swRdRef(swRdRef),
    .swRdRights(swRdRights), .swRdTag(swRdTag), .swRdPpn(swRdPpn),
    .swRdLru(swRdLru)
  );

endmodule

// File: tb/xlat_cache_test.sv
`timescale 1ns/1ps
module xlat_cache_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [39:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqKernel = 1'b0;
  logic        rspValid, rspHit, rspMiss, rspProt;
  logic [35:0] rspPaddr;
  logic        swWrEn = 1'b0;
  logic [7:0]  swWrSet = '0;
  logic        swWrWay = 1'b0;
  logic        swWrValid = 1'b0;
  logic        swWrDirty = 1'b0;
  logic [1:0]  swWrRights = '0;
  logic [17:0] swWrTag = '0;
  logic [21:0] swWrPpn = '0;
  logic        swClrRef = 1'b0;
  logic        swFlush = 1'b0;
  logic [7:0]  swRdSet = '0;
  logic        swRdWay = 1'b0;
  logic        swRdValid, swRdDirty, swRdRef, swRdLru;
  logic [1:0]  swRdRights;
  logic [17:0] swRdTag;
  logic [21:0] swRdPpn;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xlat_cache uut (.*);

  typedef struct packed {
    logic [17:0] tag;
    logic [7:0]  set;
    logic [13:0] off;
    logic        wr;
    logic        kern;
    logic [1:0]  res;   // 0 hit, 1 miss, 2 fault
    logic [21:0] ppn;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{18'h00ABC, 8'h05, 14'h1234, 1'b0, 1'b0, 2'd0, 22'h12345},  // R1 read, way 0
    '{18'h00ABC, 8'h05, 14'h0000, 1'b1, 1'b0, 2'd0, 22'h12345},  // R5 store hit
    '{18'h3FFFF, 8'h05, 14'h3FFF, 1'b0, 1'b0, 2'd0, 22'h3FFFFF}, // R3 way 1 hit
    '{18'h3FFFF, 8'h05, 14'h0001, 1'b1, 1'b0, 2'd2, 22'h0},      // R4 store to RO
    '{18'h00001, 8'hFF, 14'h0002, 1'b0, 1'b0, 2'd2, 22'h0},      // R4 user on kernel page
    '{18'h00001, 8'hFF, 14'h2AAA, 1'b1, 1'b1, 2'd0, 22'h00007},  // R4 kernel store
    '{18'h00000, 8'h00, 14'h0003, 1'b0, 1'b1, 2'd2, 22'h0},      // R4 no access
    '{18'h00ABD, 8'h05, 14'h0004, 1'b0, 1'b0, 2'd1, 22'h0},      // R3 tag mismatch
    '{18'h00ABC, 8'h06, 14'h0005, 1'b0, 1'b0, 2'd1, 22'h0},      // R3 other set
    '{18'h00ABC, 8'h05, 14'h3210, 1'b0, 1'b1, 2'd0, 22'h12345}   // R4 kernel on RW
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [39:0] va, input logic wr, input logic kern);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr; reqKernel = kern;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic install(input logic [7:0] s, input logic w, input logic v, input logic d,
                         input logic [1:0] r, input logic [17:0] t, input logic [21:0] p);
    @(negedge clk);
    swWrEn = 1'b1; swWrSet = s; swWrWay = w; swWrValid = v; swWrDirty = d;
    swWrRights = r; swWrTag = t; swWrPpn = p;
    @(negedge clk);
    swWrEn = 1'b0;
  endtask

  task automatic peek(input logic [7:0] s, input logic w);
    swRdSet = s; swRdWay = w;
    #0.5;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 rspValid", rspValid, 0);
    peek(8'h05, 1'b0);
    check("R10 valid/dirty/ref/lru", {swRdValid, swRdDirty, swRdRef, swRdLru}, 0);
    peek(8'hFF, 1'b1);
    check("R10 valid/dirty/ref/lru hi", {swRdValid, swRdDirty, swRdRef, swRdLru}, 0);

    // R8 installs
    install(8'h05, 1'b0, 1'b1, 1'b0, 2'b10, 18'h00ABC, 22'h12345);
    install(8'h05, 1'b1, 1'b1, 1'b0, 2'b01, 18'h3FFFF, 22'h3FFFFF);
    install(8'hFF, 1'b0, 1'b1, 1'b0, 2'b11, 18'h00001, 22'h00007);
    install(8'h00, 1'b1, 1'b1, 1'b0, 2'b00, 18'h00000, 22'h2AAAA);
    peek(8'h05, 1'b1);
    check("R8 readback", {swRdValid, swRdDirty, swRdRef, swRdRights, swRdTag, swRdPpn},
          {1'b1, 1'b0, 1'b0, 2'b01, 18'h3FFFF, 22'h3FFFFF});
    check("R7 lru after install way1", swRdLru, 0);

    // R1 R2 R3 R4 vector walk
    for (int i = 0; i < NVEC; i++) begin
      lookup({VECS[i].tag, VECS[i].set, VECS[i].off}, VECS[i].wr, VECS[i].kern);
      check($sformatf("R2 vec%0d flags", i), {rspValid, rspHit, rspMiss, rspProt},
            {1'b1, VECS[i].res == 2'd0, VECS[i].res == 2'd1, VECS[i].res == 2'd2});
      check($sformatf("R1 vec%0d paddr", i), rspPaddr,
            (VECS[i].res == 2'd0) ? {VECS[i].ppn, VECS[i].off} : 36'h0);
    end
    @(negedge clk);
    check("R2 idle rspValid", {rspValid, rspHit, rspMiss, rspProt}, 0);

    // R5 dirty, R6 ref, R7 lru after the walk
    peek(8'h05, 1'b0);
    check("R5 dirty after store hit", swRdDirty, 1);
    check("R6 ref way0", swRdRef, 1);
    check("R7 lru set05 after way0 hit", swRdLru, 1);
    peek(8'h05, 1'b1);
    check("R5 fault leaves dirty", swRdDirty, 0);
    check("R6 ref way1", swRdRef, 1);
    peek(8'hFF, 1'b0);
    check("R5 kernel store dirty", swRdDirty, 1);
    check("R7 lru setFF", swRdLru, 1);
    peek(8'h00, 1'b1);
    check("R6 fault no ref", swRdRef, 0);
    check("R7 fault keeps lru", swRdLru, 0);

    // R6 clear all reference bits
    @(negedge clk); swClrRef = 1'b1;
    @(negedge clk); swClrRef = 1'b0;
    peek(8'h05, 1'b0);
    check("R6 clear ref", {swRdRef, swRdDirty}, 2'b01);
    peek(8'hFF, 1'b0);
    check("R6 clear ref setFF", swRdRef, 0);

    // R6 install clears ref
    lookup({18'h00ABC, 8'h05, 14'h0}, 1'b0, 1'b0);
    install(8'h05, 1'b0, 1'b1, 1'b0, 2'b10, 18'h00ABC, 22'h12345);
    peek(8'h05, 1'b0);
    check("R6 install clears ref", {swRdRef, swRdDirty}, 0);

    // R9 flush
    @(negedge clk); swFlush = 1'b1;
    @(negedge clk); swFlush = 1'b0;
    peek(8'h05, 1'b0);
    check("R9 flush valid", {swRdValid, swRdTag}, {1'b0, 18'h00ABC});
    lookup({18'h00ABC, 8'h05, 14'h0}, 1'b0, 1'b0);
    check("R9 miss after flush", {rspHit, rspMiss, rspPaddr}, {1'b0, 1'b1, 36'h0});
    install(8'h05, 1'b1, 1'b1, 1'b0, 2'b10, 18'h00ABC, 22'h0BEEF);
    lookup({18'h00ABC, 8'h05, 14'h0111}, 1'b0, 1'b0);
    check("R1 refill hit", {rspHit, rspPaddr}, {1'b1, 22'h0BEEF, 14'h0111});

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule